// File: doc/BRIEF.md
# First-Hit Strip Address Capture

This block sits behind a bank of 64 strip discriminators. Each discriminator output is already qualified by a programmable charge threshold. The block works on a fast sampling clock. A one-tick marker input, `bx_i`, sets the boundaries of the bunch-crossing windows. The block takes no account of the crossing frequency or of how many sampling ticks a window holds.

In each window the block keeps only the channel whose rising edge came first. It ignores every later edge in that window. It counts the sampling ticks from the capture to the closing marker and saturates that count at the width of the fine-time field. When the marker closes the window, the block presents one result word and holds it until the next marker. The result word is the valid flag, the 6-bit strip address and the fine time. This gives the trigger path one address per chip per crossing in place of 64 channel levels.

Top module: `first_hit_capture`

## Requirements
- R1: While reset (`rst_ni` low) is asserted, and after it is released until the first closing marker, `word_o` is all zeros.
- R2: Take a rising edge on channel c, where the input is low at one sampling edge k-1 and high at edge k. That edge is captured at sampling edge k+2. At the closing marker of the window holding that capture edge, the result word is valid=1 and addr=c. The word layout is bit 9 valid, bits 8:3 address and bits 2:0 fine time.
- R3: Once a window has captured a channel, later rising edges in the same window leave the address and fine time unchanged, even when they come from lower-numbered channels.
- R4: When several channels reach their capture edge in the same sampling tick, the lowest-numbered channel is the one reported.
- R5: The fine time is the number of sampling edges strictly between the capture edge and the closing edge. It saturates at 7.
- R6: `word_o` changes only at a sampling edge where `bx_i` is high. A window with no capture yields the all-zero word.
- R7: A channel held high over several windows gives one capture only. It must go low and rise again to be captured anew.
- R8: The window length comes only from the spacing of `bx_i` markers, and any spacing of at least one tick works. A capture edge that coincides with a marker belongs to the window that the marker opens.
- R9: An input pulse high for exactly one sampling tick is captured like a longer one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_i | input | 1 | One-tick marker closing the current window and opening the next |
| hit_i | input | 64 | Threshold-qualified discriminator outputs, one per strip |
| word_o | output | 10 | Result word {valid, address[5:0], fine[2:0]} |

## Verification
A rising input seen at sampling edge k reaches the capture stage at edge k+2, after two synchronizer stages. The result word is loaded at the same edge that samples the closing marker.

The bench keeps a two-deep delay line of rising-edge vectors and an arithmetic window model. It drives inputs and compares the whole word on every falling edge. Each comparison therefore checks the register value left by the edge just passed, whether that edge closed a window or only had to hold the word.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
    localparam int unsigned CH_DEFAULT = 64;
    localparam int unsigned FT_DEFAULT = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } cap_state_e;
endpackage

// File: rtl/fhc_sync.sv
module fhc_sync #(
    parameter int unsigned N_CH = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_CH-1:0] hit_i,
    output logic [N_CH-1:0] rise_o
);
    typedef struct packed {
        logic [N_CH-1:0] s1;
        logic [N_CH-1:0] s2;
        logic [N_CH-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = hit_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rise_o = q.s2 & ~q.s3;

    // A reported edge must trace back to an input high two edges earlier
    p_rise_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise_o & ~$past(hit_i, 2)) == '0));

    // A held level cannot report an edge two ticks running
    p_rise_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/fhc_pick.sv
module fhc_pick #(
    parameter int unsigned N_CH   = 64,
    parameter int unsigned ADDR_W = $clog2(N_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CH-1:0]   req_i,
    output logic              any_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [N_CH-1:0] grant;

    always_comb begin
        grant  = '0;
        addr_o = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                addr_o   = ADDR_W'(i);
            end
        end
    end

    assign any_o = |req_i;

    p_grant_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    p_grant_lowest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant != '0) |-> ((req_i & (grant - 1'b1)) == '0));

    p_grant_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> ((grant & req_i) == grant) && (grant != '0));
endmodule

// File: rtl/fhc_capture.sv
module fhc_capture
    import fhc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned FT_W   = 3,
    localparam int unsigned WORD_W = 1 + ADDR_W + FT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bx_i,
    input  logic              any_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [FT_W-1:0]   cnt;
        logic [WORD_W-1:0] word;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d = q;
        if (bx_i) begin
            d.word = (q.st == ST_HELD) ? {1'b1, q.addr, q.cnt} : '0;
            if (any_i) begin
                d.st   = ST_HELD;
                d.addr = addr_i;
            end else begin
                d.st   = ST_IDLE;
                d.addr = '0;
            end
            d.cnt = '0;
        end else if (q.st == ST_IDLE) begin
            if (any_i) begin
                d.st   = ST_HELD;
                d.addr = addr_i;
                d.cnt  = '0;
            end
        end else if (q.cnt != '1) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: ST_IDLE, addr: '0, cnt: '0, word: '0};
        else         q <= d;
    end

    assign word_o = q.word;

    p_hold_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bx_i |=> $stable(word_o));

    p_empty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_o[WORD_W-1] |-> (word_o == '0));

    p_addr_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_HELD && !bx_i) |=> $stable(q.addr) && (q.st == ST_HELD));

    p_fine_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE && any_i) |=> (q.cnt == '0) && (q.st == ST_HELD));

    p_fine_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_HELD && !bx_i && q.cnt == '1) |=> (q.cnt == '1));

    p_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bx_i && !any_i) |=> (q.st == ST_IDLE));
endmodule

// File: rtl/first_hit_capture.sv
module first_hit_capture
    import fhc_pkg::*;
#(
    parameter int unsigned N_CH = CH_DEFAULT,
    parameter int unsigned FT_W = FT_DEFAULT,
    localparam int unsigned ADDR_W = $clog2(N_CH),
    localparam int unsigned WORD_W = 1 + ADDR_W + FT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bx_i,
    input  logic [N_CH-1:0]   hit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [N_CH-1:0]   rise;
    logic              any;
    logic [ADDR_W-1:0] addr;

    fhc_sync #(.N_CH(N_CH)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (hit_i),
        .rise_o (rise)
    );

    fhc_pick #(.N_CH(N_CH), .ADDR_W(ADDR_W)) pick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (rise),
        .any_o  (any),
        .addr_o (addr)
    );

    fhc_capture #(.ADDR_W(ADDR_W), .FT_W(FT_W)) cap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bx_i   (bx_i),
        .any_i  (any),
        .addr_i (addr),
        .word_o (word_o)
    );
endmodule

// File: tb/first_hit_capture_tb_top.sv
module first_hit_capture_tb_top;
    logic        clk    = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bx     = 1'b0;
    logic [63:0] hit    = '0;
    logic [9:0]  word;

    always #2 clk = ~clk;

    first_hit_capture dut_i (
        .clk_i  (clk),
        .rst_ni (rst_ni),
        .bx_i   (bx),
        .hit_i  (hit),
        .word_o (word)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    logic        m_held = 0;
    logic [5:0]  m_addr = '0;
    logic [2:0]  m_cnt  = '0;
    logic [9:0]  exp_word = '0;
    logic [63:0] prev_v = '0, rd1 = '0, rd2 = '0;

    function automatic int lowest(input logic [63:0] r);
        for (int i = 0; i < 64; i++) if (r[i]) return i;
        return 0;
    endfunction

    task automatic check_word();
        n_cmp++;
        if (word !== exp_word) begin
            n_bad++;
            $display("FAIL %s: word=%h expected=%h", cur_req, word, exp_word);
        end
    endtask

    task automatic step(input logic [63:0] v, input logic b);
        logic [63:0] r;
        @(negedge clk);
        check_word();
        hit = v;
        bx  = b;
        r   = rd2;
        rd2 = rd1;
        rd1 = v & ~prev_v;
        prev_v = v;
        if (b) begin
            exp_word = m_held ? {1'b1, m_addr, m_cnt} : 10'd0;
            m_held = (r != 0);
            m_addr = (r != 0) ? 6'(lowest(r)) : 6'd0;
            m_cnt  = 3'd0;
        end else if (!m_held) begin
            if (r != 0) begin
                m_held = 1'b1;
                m_addr = 6'(lowest(r));
                m_cnt  = 3'd0;
            end
        end else if (m_cnt != 3'd7) begin
            m_cnt = m_cnt + 3'd1;
        end
    endtask

    task automatic window(input int len, input int ch_a, input int pos_a,
                          input int ch_b, input int pos_b);
        for (int t = 0; t < len; t++) begin
            logic [63:0] v;
            v = '0;
            if (t == pos_a && ch_a >= 0) v[ch_a] = 1'b1;
            if (t == pos_b && ch_b >= 0) v[ch_b] = 1'b1;
            step(v, t == len - 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) begin
            @(negedge clk);
            hit = 64'hFFFF_0000_FFFF_0000;
            check_word();
        end
        hit = '0;
        @(negedge clk);
        rst_ni = 1'b1;
        window(8, -1, -1, -1, -1);

        // R2 R5 R9: every channel, every tick position, one-tick pulses
        cur_req = "R2 R5 R9";
        for (int ch = 0; ch < 64; ch++)
            for (int pos = 0; pos < 8; pos++)
                window(8, ch, pos, -1, -1);
        window(8, -1, -1, -1, -1);

        // R4: simultaneous edges, lowest index wins
        cur_req = "R4";
        for (int i = 0; i < 32; i++) window(8, 63 - i, 3, i, 3);
        window(8, -1, -1, -1, -1);

        // R3: later lower-numbered edge is suppressed
        cur_req = "R3";
        for (int i = 0; i < 16; i++) window(8, 40 + i, 1, i, 4);
        window(8, -1, -1, -1, -1);

        // R7: level held across windows gives one capture
        cur_req = "R7";
        for (int t = 0; t < 32; t++) step(64'h20, (t % 8) == 7);
        for (int t = 0; t < 8; t++)  step(64'h0,  t == 7);
        for (int t = 0; t < 16; t++) step(64'h20, (t % 8) == 7);
        window(8, -1, -1, -1, -1);

        // R8 R5: other window lengths, including saturation
        cur_req = "R8 R5";
        for (int pos = 0; pos < 12; pos++) window(12, 7, pos, -1, -1);
        for (int pos = 0; pos < 5; pos++)  window(5, 9, pos, -1, -1);
        for (int pos = 0; pos < 3; pos++)  window(1, 11, 0, -1, -1);
        window(8, -1, -1, -1, -1);

        // R6: empty windows yield zero, word held between markers
        cur_req = "R6";
        window(8, 2, 0, -1, -1);
        for (int i = 0; i < 4; i++) window(8, -1, -1, -1, -1);

        @(negedge clk);
        check_word();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule